// File: doc/BRIEF.md
# Pipeline Exception Status Tracker

This block is the control slice of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that tracks exception status. Each instruction carries a two-bit status code, a valid bit and its PC through the decode, execute, memory and write-back pipeline registers. The fetch stage classifies the instruction from three fault flags. The memory stage can turn a clean status into a bad-address status. An exception is raised only when a faulting instruction reaches write-back, so faults take effect in program order. A faulting instruction that is cancelled before write-back, such as a wrong-path fetch after a mispredicted branch, never raises anything.

The block also stops younger instructions from changing architectural state. The condition-code write enable for execute drops in the same cycle that the memory stage holds a fault. Both that enable and the memory write enable drop while a faulting instruction sits in write-back. When the exception is raised, a small controller moves from state RUN to state FROZEN. Its transition RUN->FROZEN is taken on the cycle `exc_taken` is high. FROZEN has a self-loop and is left only through reset (FROZEN->RUN on reset). In FROZEN every pipeline register holds its value, both write enables stay low, and the cause code and PC of the faulting instruction are presented.

The datapath feeds the fetch fault flags, the memory bad-data-address flag and two pipeline control inputs. `hold_dec` stalls decode and puts a bubble into execute. `squash` cancels the instructions in decode and fetch. The datapath uses the two enables and the exception outputs that come back.

Top module: `pxt_top`

## Requirements
- R1: After reset every stage status reads AOK (code 0), `exc_taken` and `frozen` are low, and both write enables are low because the pipeline holds only bubbles.
- R2: Status codes are AOK=0, ADR=1, INS=2, HLT=3. `f_stat` is ADR when `f_bad_addr` is high, otherwise INS when `f_bad_op` is high, otherwise HLT when `f_halt` is high, otherwise AOK.
- R3: Decode and execute pass the status unchanged. A status fetched in cycle 0 shows on `d_stat`, `e_stat`, `m_stat` and `w_stat` after clock edges 1, 2, 3 and 4 respectively.
- R4: At the memory-to-write-back transfer, a valid AOK instruction with `m_bad_daddr` high arrives in write-back as ADR. A non-AOK status passes unchanged.
- R5: `exc_taken` is high for exactly one cycle, in the cycle a valid non-AOK instruction is in write-back while the controller is in state RUN. After the next edge, `exc_code` and `exc_pc` give its status and PC.
- R6: `cc_en` is high when execute holds a valid instruction, unless the memory stage holds a fault or write-back holds a non-AOK status. A memory-stage fault means a non-AOK incoming status, or AOK with `m_bad_daddr`.
- R7: `mem_we_en` is high when the memory stage holds a valid instruction, unless write-back holds a non-AOK status.
- R8: `squash` turns decode and execute into bubbles at the next edge, and a fault they carried is never raised.
- R9: `hold_dec` without `squash` keeps the decode register and puts a bubble into execute. Fetch inputs are ignored on that edge.
- R10: A bubble has status AOK. `m_bad_daddr` on a bubble in the memory stage raises nothing, and `mem_we_en` stays low for it.
- R11: From the edge after `exc_taken`, the state is FROZEN until reset. All stage statuses, `exc_code` and `exc_pc` stay stable, and both enables stay low whatever the inputs.
- R12: When an older instruction faults in memory and a younger one carries a fetch fault, the older one's status and PC are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_pc | input | PC_W | PC of the instruction in fetch |
| f_bad_addr | input | 1 | Fetch address invalid |
| f_bad_op | input | 1 | Opcode invalid |
| f_halt | input | 1 | Halt instruction fetched |
| m_bad_daddr | input | 1 | Memory-stage data address invalid |
| hold_dec | input | 1 | Stall decode, bubble into execute |
| squash | input | 1 | Cancel decode and fetch instructions |
| f_stat | output | 2 | Classified fetch status |
| d_stat | output | 2 | Decode register status |
| e_stat | output | 2 | Execute register status |
| m_stat | output | 2 | Memory register status (incoming) |
| w_stat | output | 2 | Write-back register status |
| cc_en | output | 1 | Condition-code write enable for execute |
| mem_we_en | output | 1 | Memory write enable |
| exc_taken | output | 1 | Exception raised this cycle |
| frozen | output | 1 | Controller in state FROZEN |
| exc_code | output | 2 | Status of the faulting instruction |
| exc_pc | output | PC_W | PC of the faulting instruction |

## Verification
The assertions assume that `m_bad_daddr` describes the instruction in the memory register during the same cycle. They also assume that the inputs settle between edges and that reset is applied before any checked cycle. The bench changes every input just after a falling edge. It sets `m_bad_daddr` only in cycles whose memory content is known from the fetch schedule. It leaves `hold_dec` and `squash` low except in the cycles a scenario names. While the block is frozen, the bench toggles all inputs on purpose, because R11 says they must have no effect.

// File: rtl/pxt_pkg.sv
package pxt_pkg;
    typedef enum logic [1:0] {
        ST_AOK = 2'd0,
        ST_ADR = 2'd1,
        ST_INS = 2'd2,
        ST_HLT = 2'd3
    } xstat_e;

    typedef enum logic {
        CT_RUN    = 1'b0,
        CT_FROZEN = 1'b1
    } ctl_state_e;

    localparam int STAT_W = 2;
    localparam int NSTAGE = 4;   // decode, execute, memory, write-back registers
endpackage

// File: rtl/pxt_fetch_class.sv
module pxt_fetch_class
    import pxt_pkg::*;
(
    input  logic   bad_addr,
    input  logic   bad_op,
    input  logic   halt,
    output xstat_e stat
);
    // R2: an unreadable address hides the opcode, so it ranks first
    always_comb begin
        if (bad_addr)      stat = ST_ADR;
        else if (bad_op)   stat = ST_INS;
        else if (halt)     stat = ST_HLT;
        else               stat = ST_AOK;
    end
endmodule

// File: rtl/pxt_stage_reg.sv
module pxt_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         bubble,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // an all-zero slot is a bubble: invalid, status AOK
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (hold)   q <= q;
        else if (bubble) q <= '0;
        else             q <= d;
    end

    a_r9_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q));

    a_r10_bubble_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble && !hold) |=> (q == '0));
endmodule

// File: rtl/pxt_ctrl.sv
module pxt_ctrl
    import pxt_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            w_fault,
    input  xstat_e          w_stat,
    input  logic [PC_W-1:0] w_pc,
    output logic            exc_taken,
    output logic            frozen,
    output xstat_e          exc_code,
    output logic [PC_W-1:0] exc_pc
);
    ctl_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            CT_RUN:    if (w_fault) state_nx = CT_FROZEN;
            CT_FROZEN: state_nx = CT_FROZEN;
            default:   state_nx = CT_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CT_RUN;
            exc_code <= ST_AOK;
            exc_pc   <= '0;
        end else begin
            state <= state_nx;
            if (state == CT_RUN && w_fault) begin
                exc_code <= w_stat;
                exc_pc   <= w_pc;
            end
        end
    end

    always_comb begin
        exc_taken = 1'b0;
        frozen    = 1'b0;
        unique case (state)
            CT_RUN:    exc_taken = w_fault;
            CT_FROZEN: frozen    = 1'b1;
            default:   exc_taken = 1'b0;
        endcase
    end

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> !exc_taken);

    a_r5_enter_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> frozen);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> (frozen && $stable(exc_pc) && $stable(exc_code)));
endmodule

// File: rtl/pxt_top.sv
module pxt_top
    import pxt_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] f_pc,
    input  logic            f_bad_addr,
    input  logic            f_bad_op,
    input  logic            f_halt,
    input  logic            m_bad_daddr,
    input  logic            hold_dec,
    input  logic            squash,
    output logic [1:0]      f_stat,
    output logic [1:0]      d_stat,
    output logic [1:0]      e_stat,
    output logic [1:0]      m_stat,
    output logic [1:0]      w_stat,
    output logic            cc_en,
    output logic            mem_we_en,
    output logic            exc_taken,
    output logic            frozen,
    output logic [1:0]      exc_code,
    output logic [PC_W-1:0] exc_pc
);
    // slot layout: {valid, status, pc}
    localparam int SW     = PC_W + STAT_W + 1;
    localparam int VLD_B  = SW - 1;
    localparam int ST_LSB = PC_W;
    localparam int I_DEC  = 0;
    localparam int I_EXE  = 1;
    localparam int I_MEM  = 2;
    localparam int I_WB   = 3;

    xstat_e              f_cls;
    logic [SW-1:0]       s_d [NSTAGE];
    logic [SW-1:0]       s_q [NSTAGE];
    logic [NSTAGE-1:0]   st_hold;
    logic [NSTAGE-1:0]   st_bub;
    logic                stop;
    logic                e_vld, m_vld, w_vld;
    xstat_e              m_in_st, m_out_st, w_st, ctl_code;
    logic                m_fault_now, w_fault;

    pxt_fetch_class u_fcls (
        .bad_addr (f_bad_addr),
        .bad_op   (f_bad_op),
        .halt     (f_halt),
        .stat     (f_cls)
    );

    assign e_vld   = s_q[I_EXE][VLD_B];
    assign m_vld   = s_q[I_MEM][VLD_B];
    assign w_vld   = s_q[I_WB][VLD_B];
    assign m_in_st = xstat_e'(s_q[I_MEM][ST_LSB +: STAT_W]);
    assign w_st    = xstat_e'(s_q[I_WB][ST_LSB +: STAT_W]);

    // R4: memory stage may only overwrite a clean status
    always_comb begin
        m_out_st = m_in_st;
        if (m_vld && m_in_st == ST_AOK && m_bad_daddr) m_out_st = ST_ADR;
    end

    assign m_fault_now = m_vld && (m_out_st != ST_AOK);
    assign w_fault     = w_vld && (w_st != ST_AOK);

    // stage inputs
    always_comb begin
        s_d[I_DEC] = {1'b1, f_cls, f_pc};
        s_d[I_EXE] = s_q[I_DEC];
        s_d[I_MEM] = s_q[I_EXE];
        s_d[I_WB]  = {m_vld, m_out_st, s_q[I_MEM][PC_W-1:0]};
    end

    // pipeline control: freezing outranks squash, squash outranks stall
    assign stop = frozen | exc_taken;
    always_comb begin
        st_hold        = {NSTAGE{stop}};
        st_bub         = '0;
        st_hold[I_DEC] = stop | (hold_dec & ~squash);
        st_bub[I_DEC]  = squash & ~stop;
        st_bub[I_EXE]  = (squash | hold_dec) & ~stop;
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        pxt_stage_reg #(.W(SW)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold   (st_hold[g]),
            .bubble (st_bub[g]),
            .d      (s_d[g]),
            .q      (s_q[g])
        );
    end

    pxt_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .w_fault   (w_fault),
        .w_stat    (w_st),
        .w_pc      (s_q[I_WB][PC_W-1:0]),
        .exc_taken (exc_taken),
        .frozen    (frozen),
        .exc_code  (ctl_code),
        .exc_pc    (exc_pc)
    );

    // R6 / R7 side-effect guards
    assign cc_en     = ~frozen & e_vld & ~m_fault_now & ~w_fault;
    assign mem_we_en = ~frozen & m_vld & ~w_fault;

    assign f_stat   = f_cls;
    assign d_stat   = s_q[I_DEC][ST_LSB +: STAT_W];
    assign e_stat   = s_q[I_EXE][ST_LSB +: STAT_W];
    assign m_stat   = m_in_st;
    assign w_stat   = w_st;
    assign exc_code = ctl_code;

    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !squash && !hold_dec) |=> (e_stat == $past(d_stat)));

    a_r4_merge_adr: assert property (@(posedge clk) disable iff (!rst_n)
        (m_vld && m_in_st == ST_AOK && m_bad_daddr && !stop) |=> (w_stat == ST_ADR));

    a_r7_raise_guard: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (!mem_we_en && !cc_en));

    a_r8_squash_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && !stop) |=> (d_stat == ST_AOK && e_stat == ST_AOK));

    a_r11_no_effects: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> (!cc_en && !mem_we_en && !exc_taken));
endmodule

// File: tb/pxt_top_test.sv
module pxt_top_test;
    localparam int PERIOD = 10;
    localparam int PC_W   = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] f_pc;
    logic            f_bad_addr, f_bad_op, f_halt, m_bad_daddr, hold_dec, squash;
    logic [1:0]      f_stat, d_stat, e_stat, m_stat, w_stat, exc_code;
    logic            cc_en, mem_we_en, exc_taken, frozen;
    logic [PC_W-1:0] exc_pc;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(PERIOD/2) clk = ~clk;

    pxt_top #(.PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .f_pc(f_pc),
        .f_bad_addr(f_bad_addr), .f_bad_op(f_bad_op), .f_halt(f_halt),
        .m_bad_daddr(m_bad_daddr), .hold_dec(hold_dec), .squash(squash),
        .f_stat(f_stat), .d_stat(d_stat), .e_stat(e_stat), .m_stat(m_stat),
        .w_stat(w_stat), .cc_en(cc_en), .mem_we_en(mem_we_en),
        .exc_taken(exc_taken), .frozen(frozen), .exc_code(exc_code), .exc_pc(exc_pc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put(input logic [PC_W-1:0] pc, input logic a, input logic o, input logic h);
        f_pc = pc; f_bad_addr = a; f_bad_op = o; f_halt = h;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        put('0, 0, 0, 0);
        m_bad_daddr = 0; hold_dec = 0; squash = 0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1 d_stat", d_stat, 0);
        check("R1 e_stat", e_stat, 0);
        check("R1 m_stat", m_stat, 0);
        check("R1 w_stat", w_stat, 0);
        check("R1 exc_taken", exc_taken, 0);
        check("R1 frozen", frozen, 0);
        check("R1 cc_en", cc_en, 0);
        check("R1 mem_we_en", mem_we_en, 0);
    endtask

    task automatic t_classify();
        do_reset();
        put(1, 0, 0, 0); #1 check("R2 clean", f_stat, 0);
        put(1, 0, 0, 1); #1 check("R2 halt", f_stat, 3);
        put(1, 0, 1, 1); #1 check("R2 op over halt", f_stat, 2);
        put(1, 1, 1, 1); #1 check("R2 addr first", f_stat, 1);
        put(1, 1, 0, 0); #1 check("R2 addr", f_stat, 1);
    endtask

    task automatic t_flow();
        do_reset();
        put(16'h10, 0, 1, 0);
        step(); put(16'h11, 0, 0, 0); #1 check("R3 d_stat", d_stat, 2);
        step(); put(16'h12, 0, 0, 0); #1 check("R3 e_stat", e_stat, 2);
        check("R6 cc_en clean", cc_en, 1);
        step(); put(16'h13, 0, 0, 0); #1 check("R3 m_stat", m_stat, 2);
        check("R6 cc_en mem fault", cc_en, 0);
        check("R7 mem_we_en open", mem_we_en, 1);
        step(); put(16'h14, 0, 0, 0); #1 check("R3 w_stat", w_stat, 2);
        check("R5 exc_taken", exc_taken, 1);
        check("R7 mem_we_en blocked", mem_we_en, 0);
        check("R6 cc_en wb fault", cc_en, 0);
        step(); #1 check("R5 pulse ends", exc_taken, 0);
        check("R11 frozen", frozen, 1);
        check("R5 exc_code", exc_code, 2);
        check("R5 exc_pc", exc_pc, 16'h10);
    endtask

    task automatic t_mem_fault();
        do_reset();
        put(16'h20, 0, 0, 0);
        step(); put(16'h21, 0, 1, 0);
        step(); put(16'h22, 0, 0, 0);
        step(); m_bad_daddr = 1; #1 check("R6 cc_en bad daddr", cc_en, 0);
        check("R7 mem_we_en before raise", mem_we_en, 1);
        step(); m_bad_daddr = 0; #1 check("R4 adr merged", w_stat, 1);
        check("R12 younger in mem", m_stat, 2);
        check("R12 raise", exc_taken, 1);
        step(); #1 check("R12 exc_code", exc_code, 1);
        check("R12 exc_pc", exc_pc, 16'h20);
    endtask

    task automatic t_mem_keep();
        do_reset();
        put(16'h60, 0, 1, 0);
        step(); put(16'h61, 0, 0, 0);
        step(); step(); m_bad_daddr = 1;
        step(); m_bad_daddr = 0; #1 check("R4 ins kept", w_stat, 2);
        step(); #1 check("R4 code kept", exc_code, 2);
    endtask

    task automatic t_squash();
        bit seen;
        do_reset();
        put(16'h30, 1, 0, 0);
        step(); put(16'h31, 0, 0, 0); squash = 1; #1 check("R8 d before", d_stat, 1);
        step(); squash = 0; #1 check("R8 d bubble", d_stat, 0);
        check("R8 e bubble", e_stat, 0);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            step(); #1 if (exc_taken || frozen) seen = 1;
        end
        check("R8 never raised", seen, 0);
    endtask

    task automatic t_hold();
        do_reset();
        put(16'h40, 0, 0, 1);
        step(); put(16'h41, 0, 0, 0); hold_dec = 1; #1 check("R9 d loaded", d_stat, 3);
        step(); hold_dec = 0; #1 check("R9 d kept", d_stat, 3);
        check("R9 e bubble", e_stat, 0);
        step(); #1 check("R9 e after", e_stat, 3);
        step(); step(); #1 check("R9 raise", exc_taken, 1);
        step(); #1 check("R9 exc_pc", exc_pc, 16'h40);
        check("R9 exc_code", exc_code, 3);
    endtask

    task automatic t_bubble();
        bit seen;
        do_reset();
        put(16'h50, 0, 0, 0);
        m_bad_daddr = 1;
        #1 check("R10 mem_we_en bubble", mem_we_en, 0);
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            step(); put(16'h51 + i[PC_W-1:0], 0, 0, 0);
            if (i == 2) m_bad_daddr = 0;
            #1 if (exc_taken || w_stat != 0) seen = 1;
        end
        step(); #1 if (exc_taken || w_stat != 0) seen = 1;
        check("R10 bubble ignored", seen, 0);
    endtask

    task automatic t_freeze();
        bit moved;
        do_reset();
        put(16'h70, 0, 0, 1);
        for (int i = 1; i <= 4; i++) begin
            step(); put(16'h70 + i[PC_W-1:0], 0, 0, 0);
        end
        step(); #1 check("R11 entered", frozen, 1);
        moved = 0;
        for (int i = 0; i < 5; i++) begin
            put(16'hFF, 1, 1, 1); m_bad_daddr = 1; squash = i[0]; hold_dec = i[1];
            step(); #1
            if (d_stat != 0 || e_stat != 0 || m_stat != 0 || w_stat != 3) moved = 1;
            if (cc_en || mem_we_en || exc_taken || !frozen) moved = 1;
            if (exc_pc != 16'h70 || exc_code != 3) moved = 1;
        end
        check("R11 stable while frozen", moved, 0);
        do_reset(); #1 check("R11 reset leaves frozen", frozen, 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_classify();
        t_flow();
        t_mem_fault();
        t_mem_keep();
        t_squash();
        t_hold();
        t_bubble();
        t_freeze();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule